// File: doc/BRIEF.md
# ECC Error Logging Unit

This block sits beside a memory ECC checker that guards 72-bit words (64 data bits and 8 check bits). On every access, the checker reports two things to the block. It raises a strobe when it has corrected an error and a different strobe when an error cannot be corrected. With either strobe it supplies the address of the failing word. The block keeps two separate records, one for each error class. Each record holds the address of the latest error of that class and a saturating count of errors of that class.

Software reads the records through a simple read port. The read returns data one cycle after the request. Each error class drives its own interrupt line. A strobe of that class sets the line. The line clears as a side effect of reading that class's count register. If a new error arrives in the same cycle as a clearing read, the new error takes priority.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, both address records and both counts read as zero, and both interrupt outputs are low.
- R2: A corrected strobe stores `errAddr` into the corrected-address record. That record reads at byte offset 0x140, zero-extended to the data width. `rdData` changes only in the cycle after a cycle in which `rdEn` is high, and holds otherwise.
- R3: Each corrected strobe adds one to the corrected count. That count reads at offset 0x148.
- R4: An uncorrectable strobe stores `errAddr` into the uncorrectable-address record. That record reads at offset 0x160.
- R5: Each uncorrectable strobe adds one to the uncorrectable count. That count reads at offset 0x168.
- R6: Both counts stop at all ones and never wrap to zero.
- R7: `fixIrq` is high from the cycle after a corrected strobe until the cycle after a read of offset 0x148.
- R8: `failIrq` is high from the cycle after an uncorrectable strobe until the cycle after a read of offset 0x168.
- R9: If a strobe coincides with a read of the same class's count, the interrupt stays high. The read returns the count as it stood before that strobe.
- R10: Corrected and uncorrectable strobes in the same cycle both update their own records.
- R11: Reads of the address offsets, or of any other offset, leave both interrupts unchanged. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| fixStrobe | input | 1 | Corrected error seen this cycle |
| failStrobe | input | 1 | Uncorrectable error seen this cycle |
| errAddr | input | ADDR_W | Address of the word that failed |
| rdEn | input | 1 | Read request |
| rdAddr | input | OFF_W | Byte offset of the read |
| rdData | output | DATA_W | Read result, one cycle after the request |
| fixIrq | output | 1 | Corrected-error interrupt |
| failIrq | output | 1 | Uncorrectable-error interrupt |

## Verification
Two functions can land on the same clock edge: logging a new error, and the read that clears that class's interrupt. The bench forces this collision directly, with a strobe aligned to a count read for each class. Random traffic also lets the two meet at their natural rate. A bench model keeps the pre-edge count as the read result and gives the error priority over the clear, and each collision is judged against that model.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int OFS_FIX_ADDR  = 'h140;
  localparam int OFS_FIX_CNT   = 'h148;
  localparam int OFS_FAIL_ADDR = 'h160;
  localparam int OFS_FAIL_CNT  = 'h168;
  localparam int NUM_CLASSES   = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_FIX_ADDR, SEL_FIX_CNT, SEL_FAIL_ADDR, SEL_FAIL_CNT
  } rdSel_e;

  typedef struct packed {
    logic   fixLog;
    logic   failLog;
    logic   rdStb;
    rdSel_e rdSel;
  } logStrobes_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fixStrobe,
  input  logic             failStrobe,
  input  logic             rdEn,
  input  logic [OFF_W-1:0] rdAddr,
  output logStrobes_t      strobes,
  output logic             fixIrq,
  output logic             failIrq
);
  rdSel_e rdSel;
  logic [NUM_CLASSES-1:0] logIn, clrIn, irqQ;

  always_comb begin
    rdSel = SEL_NONE;
    if (rdAddr == OFF_W'(OFS_FIX_ADDR))       rdSel = SEL_FIX_ADDR;
    else if (rdAddr == OFF_W'(OFS_FIX_CNT))   rdSel = SEL_FIX_CNT;
    else if (rdAddr == OFF_W'(OFS_FAIL_ADDR)) rdSel = SEL_FAIL_ADDR;
    else if (rdAddr == OFF_W'(OFS_FAIL_CNT))  rdSel = SEL_FAIL_CNT;
  end

  always_comb begin
    strobes.fixLog  = fixStrobe;
    strobes.failLog = failStrobe;
    strobes.rdStb   = rdEn;
    strobes.rdSel   = rdSel;
    logIn = {failStrobe, fixStrobe};
    clrIn = {rdEn && (rdSel == SEL_FAIL_CNT), rdEn && (rdSel == SEL_FIX_CNT)};
  end

  // a new error dominates a read-clear on the same edge
  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rstN)         irqQ[k] <= 1'b0;
      else if (logIn[k]) irqQ[k] <= 1'b1;
      else if (clrIn[k]) irqQ[k] <= 1'b0;
    end
  end

  assign fixIrq  = irqQ[0];
  assign failIrq = irqQ[1];
endmodule

// File: rtl/ecc_log_dpath.sv
module ecc_log_dpath
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 38,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] errAddr,
  input  logStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] fixAddr,
  output logic [CNT_W-1:0]  fixCnt,
  output logic [ADDR_W-1:0] failAddr,
  output logic [CNT_W-1:0]  failCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_CLASSES-1:0] logIn;
  logic [ADDR_W-1:0] addrQ [NUM_CLASSES];
  logic [CNT_W-1:0]  cntQ  [NUM_CLASSES];
  logic [DATA_W-1:0] rdNext;

  assign logIn = {strobes.failLog, strobes.fixLog};

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_rec
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[k] <= '0;
        cntQ[k]  <= '0;
      end else if (logIn[k]) begin
        addrQ[k] <= errAddr;
        if (cntQ[k] != CNT_MAX) cntQ[k] <= cntQ[k] + 1'b1;
      end
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_FIX_ADDR:  rdNext = DATA_W'(addrQ[0]);
      SEL_FIX_CNT:   rdNext = DATA_W'(cntQ[0]);
      SEL_FAIL_ADDR: rdNext = DATA_W'(addrQ[1]);
      SEL_FAIL_CNT:  rdNext = DATA_W'(cntQ[1]);
      default:       rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobes.rdStb) rdData <= rdNext;
  end

  assign fixAddr  = addrQ[0];
  assign fixCnt   = cntQ[0];
  assign failAddr = addrQ[1];
  assign failCnt  = cntQ[1];
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 38,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fixStrobe,
  input  logic              failStrobe,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              rdEn,
  input  logic [OFF_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              fixIrq,
  output logic              failIrq
);
  logStrobes_t strobes;
  logic [ADDR_W-1:0] fixAddr, failAddr;
  logic [CNT_W-1:0]  fixCnt, failCnt;

  ecc_log_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fixStrobe(fixStrobe), .failStrobe(failStrobe),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobes(strobes),
    .fixIrq(fixIrq), .failIrq(failIrq)
  );

  ecc_log_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .errAddr(errAddr), .strobes(strobes),
    .rdData(rdData), .fixAddr(fixAddr), .fixCnt(fixCnt),
    .failAddr(failAddr), .failCnt(failCnt)
  );
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 38,
  parameter int CNT_W  = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              fixStrobe,
  input logic              failStrobe,
  input logic [ADDR_W-1:0] errAddr,
  input logic              rdEn,
  input logic [OFF_W-1:0]  rdAddr,
  input logic              fixIrq,
  input logic              failIrq,
  input logic [ADDR_W-1:0] fixAddr,
  input logic [CNT_W-1:0]  fixCnt,
  input logic [ADDR_W-1:0] failAddr,
  input logic [CNT_W-1:0]  failCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_fix_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    fixStrobe |=> fixAddr == $past(errAddr));
  assert_fix_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    fixStrobe && fixCnt != CNT_MAX |=> fixCnt == $past(fixCnt) + 1'b1);
  assert_fix_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !fixStrobe |=> $stable(fixCnt));
  assert_fail_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    failStrobe |=> failAddr == $past(errAddr));
  assert_fail_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    failStrobe && failCnt != CNT_MAX |=> failCnt == $past(failCnt) + 1'b1);
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    fixCnt == CNT_MAX |=> fixCnt == CNT_MAX);
  assert_no_wrap_fail_R6: assert property (@(posedge clk) disable iff (!rstN)
    failCnt == CNT_MAX |=> failCnt == CNT_MAX);
  assert_fix_irq_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    fixStrobe |=> fixIrq);
  assert_fix_irq_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdAddr == OFF_W'(OFS_FIX_CNT) && !fixStrobe |=> !fixIrq);
  assert_fail_irq_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    failStrobe |=> failIrq);
  assert_fail_irq_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdAddr == OFF_W'(OFS_FAIL_CNT) && !failStrobe |=> !failIrq);
  assert_irq_keep_R11: assert property (@(posedge clk) disable iff (!rstN)
    fixIrq && !(rdEn && rdAddr == OFF_W'(OFS_FIX_CNT)) |=> fixIrq);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rstN(rstN), .fixStrobe(fixStrobe), .failStrobe(failStrobe),
  .errAddr(errAddr), .rdEn(rdEn), .rdAddr(rdAddr), .fixIrq(fixIrq),
  .failIrq(failIrq), .fixAddr(fixAddr), .fixCnt(fixCnt),
  .failAddr(failAddr), .failCnt(failCnt)
);

// File: tb/tb_ecc_err_logger.sv
module tb_ecc_err_logger;
  localparam int ADDR_W = 38;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 64;
  localparam int OFF_W  = 12;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fixStrobe = 1'b0, failStrobe = 1'b0, rdEn = 1'b0;
  logic [ADDR_W-1:0] errAddr = '0;
  logic [OFF_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic fixIrq, failIrq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [ADDR_W-1:0] mFixA = '0, mFailA = '0;
  logic [CNT_W-1:0]  mFixC = '0, mFailC = '0;
  logic mFixI = 1'b0, mFailI = 1'b0;
  logic [DATA_W-1:0] mRd = '0;
  string rdTag = "R1";

  always #4 clk = ~clk;

  ecc_err_logger #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rstN(rstN), .fixStrobe(fixStrobe), .failStrobe(failStrobe),
    .errAddr(errAddr), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .fixIrq(fixIrq), .failIrq(failIrq)
  );

  task automatic chk(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] expRead(logic [OFF_W-1:0] ofs);
    case (ofs)
      12'h140: return DATA_W'(mFixA);
      12'h148: return DATA_W'(mFixC);
      12'h160: return DATA_W'(mFailA);
      12'h168: return DATA_W'(mFailC);
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(logic [OFF_W-1:0] ofs);
    case (ofs)
      12'h140: return "R2";
      12'h148: return "R3";
      12'h160: return "R4";
      12'h168: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] satInc(logic [CNT_W-1:0] c);
    return (c == CMAX) ? c : c + 1'b1;
  endfunction

  task automatic step(logic fs, logic us, logic [ADDR_W-1:0] a, logic re,
                      logic [OFF_W-1:0] ra, string tag);
    @(negedge clk);
    fixStrobe = fs; failStrobe = us; errAddr = a; rdEn = re; rdAddr = ra;
    @(posedge clk);
    if (re) begin
      mRd = expRead(ra);
      rdTag = (tag != "") ? tag : tagFor(ra);
    end
    if (re && ra == 12'h148 && !fs) mFixI = 1'b0;
    if (re && ra == 12'h168 && !us) mFailI = 1'b0;
    if (fs) begin mFixA = a; mFixC = satInc(mFixC); mFixI = 1'b1; end
    if (us) begin mFailA = a; mFailC = satInc(mFailC); mFailI = 1'b1; end
    #2;
    chk(fixIrq === mFixI, (tag != "") ? tag : "R7", DATA_W'(fixIrq), DATA_W'(mFixI));
    chk(failIrq === mFailI, (tag != "") ? tag : "R8", DATA_W'(failIrq), DATA_W'(mFailI));
    chk(rdData === mRd, rdTag, rdData, mRd);
  endtask

  task automatic rd(logic [OFF_W-1:0] ra, string tag);
    step(1'b0, 1'b0, '0, 1'b1, ra, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: records and interrupts cleared by reset
    rd(12'h140, "R1"); rd(12'h148, "R1"); rd(12'h160, "R1"); rd(12'h168, "R1");
    // R2 R3 R7: corrected error logged, read, interrupt cleared by count read
    step(1'b1, 1'b0, 38'h12_3456_789A, 1'b0, '0, "");
    rd(12'h140, "R2"); rd(12'h160, "R11"); rd(12'h148, "R3"); rd(12'h148, "R7");
    // R4 R5 R8: uncorrectable path
    step(1'b0, 1'b1, 38'h3F_FFFF_FFF8, 1'b0, '0, "");
    rd(12'h160, "R4"); rd(12'h140, "R11"); rd(12'h3FC, "R11");
    rd(12'h168, "R5"); rd(12'h168, "R8");
    // R9: strobe coincides with clearing read of the same class
    step(1'b1, 1'b0, 38'h0_0000_1000, 1'b0, '0, "");
    step(1'b1, 1'b0, 38'h0_0000_2000, 1'b1, 12'h148, "R9");
    rd(12'h148, "R9");
    step(1'b0, 1'b1, 38'h0_0000_3000, 1'b1, 12'h168, "R9");
    rd(12'h168, "R9");
    // R10: both classes in one cycle
    step(1'b1, 1'b1, 38'h2A_AAAA_AAA0, 1'b0, '0, "R10");
    rd(12'h140, "R10"); rd(12'h160, "R10"); rd(12'h148, "R10"); rd(12'h168, "R10");
    // R6: push the corrected count past its limit
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, ADDR_W'(i), 1'b0, '0, "R6");
    rd(12'h148, "R6");
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, ADDR_W'(i), 1'b0, '0, "R6");
    rd(12'h168, "R6");
    // reset again, then random traffic
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    mFixA = '0; mFailA = '0; mFixC = '0; mFailC = '0;
    mFixI = 1'b0; mFailI = 1'b0; mRd = '0; rdTag = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [OFF_W-1:0] ra;
      case ($urandom_range(0, 4))
        0: ra = 12'h140;
        1: ra = 12'h148;
        2: ra = 12'h160;
        3: ra = 12'h168;
        default: ra = OFF_W'($urandom);
      endcase
      step($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
           {6'($urandom), 32'($urandom)}, $urandom_range(0, 1) == 1, ra, "");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule